// File: doc/BRIEF.md
# Invariant Error Flagging and Single-Bit Correction

This block sits behind a serial index-weighted accumulator that walks a 12-bit codeword in phases. It does not compute the accumulator itself; it watches the signed accumulator value and the phase code. At the end of the ones-count phase and again at the end of the index-sum phase, it decides whether the codeword broke the expected invariant. After the index-sum phase it also repairs a single corrupted bit.

A controller state machine arms the block on a start pulse and then accepts exactly one ones-count end strobe and then one index-sum end strobe. Its states are IDLE, AWAIT_COUNT, AWAIT_SUM and HOLD. The transitions are:

- IDLE to AWAIT_COUNT on start.
- AWAIT_COUNT to AWAIT_SUM on a ones-count end.
- AWAIT_SUM to HOLD on an index-sum end.
- Any state back to AWAIT_COUNT on start.
- Any state to IDLE on the synchronous clear.

End strobes that arrive in any other state, or that carry another phase code, are ignored.

The index-sum result is expected to be zero for a clean word. A single flipped bit at position j (1 = LSB) leaves plus or minus (2j+1) in the accumulator. The magnitude is formed by choosing 0+x or 0-x from the sign of x. Dropping the magnitude's LSB gives j, which a one-hot decoder turns into a flip mask for the received word.

Top module: `invfix_top`

## Requirements
- R1: While the synchronous clear `rst` is high, and in the cycle after it, err_count, err_sum, err_any and fixed_word are all zero.
- R2: A ones-count end accepted in AWAIT_COUNT sets err_count, one cycle later, to 1 exactly when acc_val is not 6. A ones-count end means phase_end is high with phase = 2'd1.
- R3: An index-sum end accepted in AWAIT_SUM sets err_sum, one cycle later, to 1 exactly when acc_val is nonzero. An index-sum end means phase_end is high with phase = 2'd2.
- R4: err_any takes the ones-count result. At the index-sum end it is updated only if it is still 0, so after a full run it equals err_count OR err_sum.
- R5: At the index-sum end, with j = floor(|acc_val| / 2) and acc_val read as two's complement, fixed_word equals codeword_in with only bit j (bit 1 = LSB, i.e. vector bit j-1) inverted when 1 <= j <= 12.
- R6: If acc_val is 0 at the index-sum end, fixed_word equals codeword_in.
- R7: If j is 0 (acc_val = +1 or -1) or greater than 12, including acc_val = -128, no bit is inverted and fixed_word equals codeword_in.
- R8: fixed_word is captured only at the accepted index-sum end and holds while codeword_in changes, until the next accepted index-sum end or clear.
- R9: A start pulse clears err_count, err_sum and err_any in the following cycle.
- R10: End strobes are ignored in these cases, and leave the error outputs and fixed_word unchanged:
  - an end strobe with phase = 2'd3 or 2'd0;
  - an index-sum end while in AWAIT_COUNT;
  - a ones-count end while in AWAIT_SUM;
  - any end strobe in IDLE or HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, active high |
| start | input | 1 | Arms a new run and clears the error flags |
| phase_end | input | 1 | One-cycle strobe marking the end of the phase named by `phase` |
| phase | input | 2 | Phase code: 1 ones-count, 2 index-sum, 3 value, 0 none |
| acc_val | input | ACC_W (8) | Signed accumulator value at the phase end |
| codeword_in | input | CW_W (12) | Received codeword |
| err_count | output | 1 | Ones-count invariant violated |
| err_sum | output | 1 | Index-sum invariant violated |
| err_any | output | 1 | Sticky combined error flag |
| fixed_word | output | CW_W (12) | Corrected codeword, registered at the index-sum end |

## Verification
The hardest cases to reach from the ports are the ones where correction must do nothing despite a nonzero accumulator. These are the magnitude that floors to index 0, the indices past the word's top bit, and the single negative value whose magnitude does not fit back into the signed range. The bench reaches all of them by running one complete start, ones-count, index-sum sequence for every one of the 256 accumulator values. Each run uses a different codeword, and the ones-count result alternates between passing and failing, so the sticky-flag update is exercised with both prior states.

// File: rtl/invfix_pkg.sv
package invfix_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_AWAIT_COUNT = 2'd1,
        ST_AWAIT_SUM   = 2'd2,
        ST_HOLD        = 2'd3
    } fix_state_t;

    localparam logic [1:0] PH_NONE  = 2'd0;
    localparam logic [1:0] PH_COUNT = 2'd1;
    localparam logic [1:0] PH_SUM   = 2'd2;
    localparam logic [1:0] PH_VALUE = 2'd3;

endpackage

// File: rtl/invfix_ctrl.sv
module invfix_ctrl
    import invfix_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       phase_end,
    input  logic [1:0] phase,
    output logic       cap_count,
    output logic       cap_sum
);

    fix_state_t state_q;
    fix_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_AWAIT_COUNT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_AWAIT_COUNT: begin
                    if (phase_end && (phase == PH_COUNT)) begin
                        state_d = ST_AWAIT_SUM;
                    end
                end
                ST_AWAIT_SUM: begin
                    if (phase_end && (phase == PH_SUM)) begin
                        state_d = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    state_d = ST_HOLD;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // Output logic: capture strobes for the datapath
    always_comb begin
        cap_count = 1'b0;
        cap_sum   = 1'b0;
        if (!start) begin
            unique case (state_q)
                ST_AWAIT_COUNT: cap_count = phase_end && (phase == PH_COUNT);
                ST_AWAIT_SUM:   cap_sum   = phase_end && (phase == PH_SUM);
                ST_IDLE, ST_HOLD: begin
                    cap_count = 1'b0;
                    cap_sum   = 1'b0;
                end
                default: begin
                    cap_count = 1'b0;
                    cap_sum   = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/invfix_abs.sv
module invfix_abs #(
    parameter int ACC_W = 8
) (
    input  logic signed [ACC_W-1:0] x,
    output logic        [ACC_W-1:0] mag
);

    localparam logic [ACC_W-1:0] ZERO = '0;

    logic [ACC_W-1:0] sum_pos;
    logic [ACC_W-1:0] sum_neg;

    // Both candidates are formed from zero; the sign bit picks one.
    assign sum_pos = ZERO + x;
    assign sum_neg = ZERO - x;
    assign mag     = x[ACC_W-1] ? sum_neg : sum_pos;

endmodule

// File: rtl/invfix_flipmask.sv
module invfix_flipmask #(
    parameter int MAG_W = 8,
    parameter int CW_W  = 12
) (
    input  logic [MAG_W-1:0] mag,
    output logic [CW_W-1:0]  mask
);

    logic [MAG_W-1:0] idx;

    // Floor of half the magnitude is the bit position, 1 = LSB.
    assign idx = mag >> 1;

    for (genvar i = 1; i <= CW_W; i++) begin : g_line
        assign mask[i-1] = (idx == MAG_W'(i));
    end

endmodule

// File: rtl/invfix_top.sv
module invfix_top
    import invfix_pkg::*;
#(
    parameter int CW_W  = 12,
    parameter int ACC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    phase_end,
    input  logic [1:0]              phase,
    input  logic signed [ACC_W-1:0] acc_val,
    input  logic [CW_W-1:0]         codeword_in,
    output logic                    err_count,
    output logic                    err_sum,
    output logic                    err_any,
    output logic [CW_W-1:0]         fixed_word
);

    localparam int ONES_TARGET = CW_W / 2;
    localparam logic signed [ACC_W-1:0] COUNT_GOOD = ACC_W'(ONES_TARGET);
    localparam logic signed [ACC_W-1:0] SUM_GOOD   = '0;

    logic             cap_count;
    logic             cap_sum;
    logic             bad_count;
    logic             bad_sum;
    logic [ACC_W-1:0] acc_mag;
    logic [CW_W-1:0]  flip_mask;

    invfix_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .phase_end (phase_end),
        .phase     (phase),
        .cap_count (cap_count),
        .cap_sum   (cap_sum)
    );

    invfix_abs #(.ACC_W(ACC_W)) u_abs (
        .x   (acc_val),
        .mag (acc_mag)
    );

    invfix_flipmask #(.MAG_W(ACC_W), .CW_W(CW_W)) u_mask (
        .mag  (acc_mag),
        .mask (flip_mask)
    );

    assign bad_count = (acc_val != COUNT_GOOD);
    assign bad_sum   = (acc_val != SUM_GOOD);

    // Per-phase and sticky error flags
    always_ff @(posedge clk) begin
        if (rst || start) begin
            err_count <= 1'b0;
            err_sum   <= 1'b0;
            err_any   <= 1'b0;
        end else begin
            if (cap_count) begin
                err_count <= bad_count;
                err_any   <= bad_count;
            end
            if (cap_sum) begin
                err_sum <= bad_sum;
                if (!err_any) begin
                    err_any <= bad_sum;
                end
            end
        end
    end

    // Corrected word, captured at the index-sum end
    always_ff @(posedge clk) begin
        if (rst) begin
            fixed_word <= '0;
        end else if (cap_sum) begin
            fixed_word <= codeword_in ^ flip_mask;
        end
    end

endmodule

// File: rtl/invfix_sva.sv
module invfix_sva #(
    parameter int CW_W  = 12,
    parameter int ACC_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic signed [ACC_W-1:0] acc_val,
    input logic [CW_W-1:0]         codeword_in,
    input logic                    err_count,
    input logic                    err_sum,
    input logic                    err_any,
    input logic [CW_W-1:0]         fixed_word,
    input logic                    cap_count,
    input logic                    cap_sum
);

    localparam logic signed [ACC_W-1:0] COUNT_GOOD = ACC_W'(CW_W / 2);
    localparam logic signed [ACC_W-1:0] ONE_POS    = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] ONE_NEG    = -ACC_W'(1);

    a_r1_clear_zero: assert property (@(posedge clk)
        rst |=> (!err_count && !err_sum && !err_any && fixed_word == '0));

    a_r2_count_flag: assert property (@(posedge clk) disable iff (rst)
        cap_count |=> (err_count == ($past(acc_val) != COUNT_GOOD)));

    a_r3_sum_flag: assert property (@(posedge clk) disable iff (rst)
        cap_sum |=> (err_sum == ($past(acc_val) != '0)));

    a_r4_sticky_count: assert property (@(posedge clk) disable iff (rst)
        err_count |-> err_any);

    a_r4_sticky_sum: assert property (@(posedge clk) disable iff (rst)
        err_sum |-> err_any);

    a_r5_single_flip: assert property (@(posedge clk) disable iff (rst)
        cap_sum |=> ($countones(fixed_word ^ $past(codeword_in)) <= 1));

    a_r6_clean_passthru: assert property (@(posedge clk) disable iff (rst)
        (cap_sum && acc_val == '0) |=> (fixed_word == $past(codeword_in)));

    a_r7_index_zero: assert property (@(posedge clk) disable iff (rst)
        (cap_sum && (acc_val == ONE_POS || acc_val == ONE_NEG))
            |=> (fixed_word == $past(codeword_in)));

    a_r8_hold_word: assert property (@(posedge clk) disable iff (rst)
        !cap_sum |=> $stable(fixed_word));

    a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!err_count && !err_sum && !err_any));

endmodule

bind invfix_top invfix_sva #(.CW_W(CW_W), .ACC_W(ACC_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .acc_val     (acc_val),
    .codeword_in (codeword_in),
    .err_count   (err_count),
    .err_sum     (err_sum),
    .err_any     (err_any),
    .fixed_word  (fixed_word),
    .cap_count   (cap_count),
    .cap_sum     (cap_sum)
);

// File: tb/tb_invfix_top.sv
module tb_invfix_top;

    localparam int CW_W  = 12;
    localparam int ACC_W = 8;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic                    phase_end = 1'b0;
    logic [1:0]              phase = 2'd0;
    logic signed [ACC_W-1:0] acc_val = '0;
    logic [CW_W-1:0]         codeword_in = '0;
    logic                    err_count;
    logic                    err_sum;
    logic                    err_any;
    logic [CW_W-1:0]         fixed_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    invfix_top #(.CW_W(CW_W), .ACC_W(ACC_W)) dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .phase_end   (phase_end),
        .phase       (phase),
        .acc_val     (acc_val),
        .codeword_in (codeword_in),
        .err_count   (err_count),
        .err_sum     (err_sum),
        .err_any     (err_any),
        .fixed_word  (fixed_word)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    function automatic logic [CW_W-1:0] expect_word(input logic [CW_W-1:0] cw, input int acc);
        int a;
        int j;
        a = (acc < 0) ? -acc : acc;
        j = a / 2;
        if (j >= 1 && j <= CW_W) return cw ^ (CW_W'(1) << (j - 1));
        return cw;
    endfunction

    // Drive one strobe cycle at the negative edge; outputs are valid at the next negative edge.
    task automatic strobe(input logic [1:0] ph, input logic signed [ACC_W-1:0] a);
        phase     = ph;
        acc_val   = a;
        phase_end = 1'b1;
        @(negedge clk);
        phase_end = 1'b0;
        phase     = 2'd0;
    endtask

    task automatic pulse_start;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [CW_W-1:0] held;
        @(negedge clk);
        @(negedge clk);
        // R1: clear state
        check(err_count == 0 && err_sum == 0 && err_any == 0, "R1 flags at clear",
              {err_count, err_sum, err_any}, 0);
        check(fixed_word == 0, "R1 word at clear", fixed_word, 0);
        rst = 1'b0;
        @(negedge clk);
        check(fixed_word == 0 && err_any == 0, "R1 after clear", fixed_word, 0);

        // R10: strobes in IDLE ignored
        codeword_in = 12'h5A3;
        strobe(2'd1, 8'sd3);
        strobe(2'd2, 8'sd9);
        check(err_count == 0 && err_sum == 0 && err_any == 0, "R10 idle strobes ignored",
              {err_count, err_sum, err_any}, 0);
        check(fixed_word == 0, "R10 idle word kept", fixed_word, 0);

        // R10: wrong phase codes and out-of-order strobes
        pulse_start();
        strobe(2'd3, 8'sd1);
        strobe(2'd0, 8'sd1);
        strobe(2'd2, 8'sd9);
        check(err_sum == 0 && fixed_word == 0, "R10 sum end before count ignored",
              {err_sum, fixed_word}, 0);
        strobe(2'd1, 8'sd6);
        check(err_count == 0 && err_any == 0, "R2 good count", {err_count, err_any}, 0);
        strobe(2'd1, 8'sd2);
        check(err_count == 0, "R10 second count end ignored", err_count, 0);
        strobe(2'd3, 8'sd5);
        check(err_sum == 0 && fixed_word == 0, "R10 value code ignored", {err_sum, fixed_word}, 0);

        // Full sweep of accumulator values at the index-sum end
        for (int k = 0; k < 256; k++) begin
            logic signed [ACC_W-1:0] a1;
            logic signed [ACC_W-1:0] a2;
            logic [CW_W-1:0]         cw;
            bit                      e1;
            bit                      e2;
            a2 = ACC_W'(k);
            a1 = ((k % 3) == 0) ? ACC_W'(k + 1) : 8'sd6;
            cw = CW_W'(12'hA5C ^ (k * 37));
            e1 = (a1 != 8'sd6);
            e2 = (a2 != 8'sd0);
            codeword_in = cw;
            pulse_start();
            check(err_count == 0 && err_sum == 0 && err_any == 0, "R9 start clears",
                  {err_count, err_sum, err_any}, 0);
            strobe(2'd1, a1);
            check(err_count == e1, "R2 count flag", err_count, e1);
            check(err_any == e1, "R4 sticky from count", err_any, e1);
            strobe(2'd2, a2);
            check(err_sum == e2, "R3 sum flag", err_sum, e2);
            check(err_any == (e1 | e2), "R4 sticky combined", err_any, e1 | e2);
            if (a2 == 0)
                check(fixed_word == cw, "R6 zero passthrough", fixed_word, cw);
            else if (int'(a2) == 1 || int'(a2) == -1 || int'(a2) >= 26 || int'(a2) <= -26)
                check(fixed_word == cw, "R7 no flip out of range", fixed_word, cw);
            else
                check(fixed_word == expect_word(cw, int'(a2)), "R5 single flip",
                      fixed_word, expect_word(cw, int'(a2)));
        end

        // R8: hold after capture while input and strobes change
        codeword_in = 12'h0F0;
        pulse_start();
        strobe(2'd1, 8'sd6);
        strobe(2'd2, -8'sd15);
        held = fixed_word;
        check(held == expect_word(12'h0F0, -15), "R5 negative index 7", held,
              expect_word(12'h0F0, -15));
        codeword_in = 12'hFFF;
        @(negedge clk);
        strobe(2'd2, 8'sd3);
        check(fixed_word == held, "R8 word held", fixed_word, held);
        check(err_sum == 1, "R10 hold strobe ignored", err_sum, 1);

        // R1: clear from a busy state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(fixed_word == 0 && err_any == 0 && err_sum == 0, "R1 clear after run",
              {fixed_word, err_any, err_sum}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule